// File: doc/BRIEF.md
# Exception Priority Vector Generator

This block picks the exception that a 16-bit processor core services next and supplies the address of the word that holds its handler pointer. Each cycle it resolves the requests that are present against a fixed ranking. The three reset classes rank highest. Below them come the software traps, then the two bus-protection violations, then the masked pin interrupts, and last a single peripheral request. That peripheral request has already been reduced to one winner outside this block and arrives with its own vector offset.

The core pulses a fetch strobe when it reads the vector. On that edge the block registers the winner's address and raises a one-cycle valid flag. Reset vectors are absolute. Every other vector takes the 8-bit vector base as its high byte and a per-source offset as its low byte. A maskable interrupt may be pending on one cycle and gone at the fetch. In that case the block hands out a catch-all spurious vector and does not let the fetch return nothing.

Top module: `exc_vector_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `vec_valid_o` is 0 and `vec_o` is 0x0000.
- R2: On a fetch, a power/pin/illegal-address reset wins over everything and gives 0xFFFE, a clock-monitor reset gives 0xFFFC, and a watchdog reset gives 0xFFFA, in that priority order. None of these is affected by either mask bit.
- R3: The software traps rank below resets and above everything else, and neither mask affects them. An unimplemented-opcode trap gives {base,0xF8}, a software-interrupt/debug request gives {base,0xF6}, and a system-call trap gives {base,0x12}.
- R4: A coprocessor access violation gives {base,0x16} and outranks a CPU access violation, which gives {base,0x14}. Both outrank the pin interrupts and ignore the masks.
- R5: The non-maskable pin interrupt gives {base,0xF4}. It is honoured only when `x_mask_i` is 0, and it outranks the maskable pin interrupt.
- R6: The maskable pin interrupt gives {base,0xF2} and outranks the peripheral request. Both are honoured only when `i_mask_i` is 0.
- R7: A peripheral vector is {base, `per_ofs_i` with bit 0 forced to 0}, so bit 0 of `vec_o` is always 0.
- R8: Suppose an unmasked interrupt (pin or peripheral) is present on the cycle before a fetch and no request of any kind is present at the fetch. The fetch then yields {base,0x10} with valid set. An interrupt that was masked on that earlier cycle does not cause this.
- R9: A fetch with no request present and no unmasked interrupt on the previous cycle leaves `vec_valid_o` at 0 and `vec_o` unchanged.
- R10: Without a fetch, `vec_valid_o` is 0 on the following cycle and `vec_o` holds its value, so valid is a single-cycle pulse for each fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rst_pwr_i | input | 1 | Pin, power-on, low-voltage or illegal-address reset request |
| rst_clkmon_i | input | 1 | Clock-monitor reset request |
| rst_wdog_i | input | 1 | Watchdog reset request |
| trap_op_i | input | 1 | Unimplemented-opcode trap |
| trap_swi_i | input | 1 | Software-interrupt or debug vector request |
| trap_sys_i | input | 1 | System-call trap |
| cop_viol_i | input | 1 | Coprocessor access violation |
| cpu_viol_i | input | 1 | CPU access violation |
| nmi_i | input | 1 | Non-maskable pin interrupt (X-gated) |
| irq_i | input | 1 | Maskable pin interrupt |
| per_req_i | input | 1 | Pre-resolved peripheral interrupt request |
| per_ofs_i | input | 8 | Vector offset of that peripheral request |
| x_mask_i | input | 1 | X mask bit of the core |
| i_mask_i | input | 1 | I mask bit of the core |
| vbase_i | input | 8 | Vector base, high byte of relative vectors |
| fetch_i | input | 1 | Vector-fetch strobe |
| vec_o | output | 16 | Registered vector address |
| vec_valid_o | output | 1 | One-cycle flag: `vec_o` was loaded by the last fetch |

## Verification
A fault in the ranking logic shows as a wrong vector one cycle after the fetch that exposes it. Only a request pair whose members sit on opposite sides of the fault reveals it, so the bench stacks several requests in each fetch. A stuck interrupt-history register shows in two ways. It hands out 0x10 vectors where a fetch should come back empty, or it fails to report a vanished request. Either appears on the valid flag one cycle after the fetch. A fault in mask gating shows only when a mask bit and its request are both set, which the bench drives in both polarities.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

   localparam int unsigned BASE_W = 8;
   localparam int unsigned OFS_W  = 8;
   localparam int unsigned ADDR_W = BASE_W + OFS_W;
   localparam int unsigned NSRC   = 11;
   localparam int unsigned IDX_W  = $clog2(NSRC);

   // ranking index: lower value wins
   typedef enum logic [IDX_W-1:0] {
      SRC_RST_PWR  = 4'd0,
      SRC_RST_CLK  = 4'd1,
      SRC_RST_WDOG = 4'd2,
      SRC_TRAP_OP  = 4'd3,
      SRC_TRAP_SWI = 4'd4,
      SRC_TRAP_SYS = 4'd5,
      SRC_COP_VIOL = 4'd6,
      SRC_CPU_VIOL = 4'd7,
      SRC_NMI      = 4'd8,
      SRC_IRQ      = 4'd9,
      SRC_PER      = 4'd10
   } src_e;

   localparam logic [OFS_W-1:0] OFS_SPURIOUS = 8'h10;
   localparam logic [OFS_W-1:0] OFS_RESERVED = 8'h18;

   function automatic logic [ADDR_W-1:0] vec_of(input src_e s,
                                                 input logic [BASE_W-1:0] base,
                                                 input logic [OFS_W-1:0] per_ofs);
      logic [OFS_W-1:0] ofs;
      logic             absolute;
      absolute = 1'b0;
      ofs      = '0;
      unique case (s)
         SRC_RST_PWR:  begin absolute = 1'b1; ofs = 8'hFE; end
         SRC_RST_CLK:  begin absolute = 1'b1; ofs = 8'hFC; end
         SRC_RST_WDOG: begin absolute = 1'b1; ofs = 8'hFA; end
         SRC_TRAP_OP:  ofs = 8'hF8;
         SRC_TRAP_SWI: ofs = 8'hF6;
         SRC_TRAP_SYS: ofs = 8'h12;
         SRC_COP_VIOL: ofs = 8'h16;
         SRC_CPU_VIOL: ofs = 8'h14;
         SRC_NMI:      ofs = 8'hF4;
         SRC_IRQ:      ofs = 8'hF2;
         SRC_PER:      ofs = per_ofs & 8'hFE;
         default:      ofs = OFS_SPURIOUS;
      endcase
      return absolute ? {8'hFF, ofs} : {base, ofs};
   endfunction

endpackage

// File: rtl/exc_req_gate.sv
module exc_req_gate
   import exc_vec_pkg::*;
#(
   parameter bit HAS_COP_VIOL = 1'b1,
   parameter bit HAS_CPU_VIOL = 1'b1
) (
   input  logic            rst_pwr_i,
   input  logic            rst_clkmon_i,
   input  logic            rst_wdog_i,
   input  logic            trap_op_i,
   input  logic            trap_swi_i,
   input  logic            trap_sys_i,
   input  logic            cop_viol_i,
   input  logic            cpu_viol_i,
   input  logic            nmi_i,
   input  logic            irq_i,
   input  logic            per_req_i,
   input  logic            x_mask_i,
   input  logic            i_mask_i,
   output logic [NSRC-1:0] req_o,
   output logic            intr_o
);
   logic cop_eff, cpu_eff, nmi_eff, irq_eff, per_eff;

   generate
      if (HAS_COP_VIOL) begin : g_cop
         assign cop_eff = cop_viol_i;
      end else begin : g_no_cop
         assign cop_eff = 1'b0;
      end
      if (HAS_CPU_VIOL) begin : g_cpu
         assign cpu_eff = cpu_viol_i;
      end else begin : g_no_cpu
         assign cpu_eff = 1'b0;
      end
   endgenerate

   assign nmi_eff = nmi_i & ~x_mask_i;
   assign irq_eff = irq_i & ~i_mask_i;
   assign per_eff = per_req_i & ~i_mask_i;

   always_comb begin
      req_o               = '0;
      req_o[SRC_RST_PWR]  = rst_pwr_i;
      req_o[SRC_RST_CLK]  = rst_clkmon_i;
      req_o[SRC_RST_WDOG] = rst_wdog_i;
      req_o[SRC_TRAP_OP]  = trap_op_i;
      req_o[SRC_TRAP_SWI] = trap_swi_i;
      req_o[SRC_TRAP_SYS] = trap_sys_i;
      req_o[SRC_COP_VIOL] = cop_eff;
      req_o[SRC_CPU_VIOL] = cpu_eff;
      req_o[SRC_NMI]      = nmi_eff;
      req_o[SRC_IRQ]      = irq_eff;
      req_o[SRC_PER]      = per_eff;
   end

   assign intr_o = nmi_eff | irq_eff | per_eff;
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
   import exc_vec_pkg::*;
(
   input  logic [NSRC-1:0]   req_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [OFS_W-1:0]  per_ofs_i,
   output logic              any_o,
   output logic [ADDR_W-1:0] vec_o
);
   src_e win;

   always_comb begin
      win = SRC_PER;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (req_i[k]) win = src_e'(k);
      end
   end

   assign any_o = |req_i;
   assign vec_o = vec_of(win, base_i, per_ofs_i);
endmodule

// File: rtl/exc_vec_capture.sv
module exc_vec_capture
   import exc_vec_pkg::*;
#(
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fetch_i,
   input  logic              any_i,
   input  logic              intr_i,
   input  logic [ADDR_W-1:0] win_vec_i,
   input  logic [BASE_W-1:0] base_i,
   output logic [ADDR_W-1:0] vec_o,
   output logic              valid_o
);
   logic intr_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         intr_q  <= 1'b0;
         vec_o   <= RESET_VEC;
         valid_o <= 1'b0;
      end else begin
         intr_q  <= intr_i;
         valid_o <= 1'b0;
         if (fetch_i) begin
            if (any_i) begin
               vec_o   <= win_vec_i;
               valid_o <= 1'b1;
            end else if (intr_q) begin
               vec_o   <= {base_i, OFS_SPURIOUS};
               valid_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_vec_pkg::*;
#(
   parameter int unsigned VEC_W        = 16,
   parameter bit          HAS_COP_VIOL = 1'b1,
   parameter bit          HAS_CPU_VIOL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rst_pwr_i,
   input  logic             rst_clkmon_i,
   input  logic             rst_wdog_i,
   input  logic             trap_op_i,
   input  logic             trap_swi_i,
   input  logic             trap_sys_i,
   input  logic             cop_viol_i,
   input  logic             cpu_viol_i,
   input  logic             nmi_i,
   input  logic             irq_i,
   input  logic             per_req_i,
   input  logic [7:0]       per_ofs_i,
   input  logic             x_mask_i,
   input  logic             i_mask_i,
   input  logic [7:0]       vbase_i,
   input  logic             fetch_i,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_valid_o
);
   generate
      if (VEC_W != ADDR_W) begin : g_bad_width
         $error("exc_vector_gen: VEC_W must equal base plus offset width");
      end
   endgenerate

   logic [NSRC-1:0]   req;
   logic              intr;
   logic              any;
   logic [ADDR_W-1:0] win_vec;

   exc_req_gate #(
      .HAS_COP_VIOL(HAS_COP_VIOL),
      .HAS_CPU_VIOL(HAS_CPU_VIOL)
   ) u_gate (
      .rst_pwr_i   (rst_pwr_i),
      .rst_clkmon_i(rst_clkmon_i),
      .rst_wdog_i  (rst_wdog_i),
      .trap_op_i   (trap_op_i),
      .trap_swi_i  (trap_swi_i),
      .trap_sys_i  (trap_sys_i),
      .cop_viol_i  (cop_viol_i),
      .cpu_viol_i  (cpu_viol_i),
      .nmi_i       (nmi_i),
      .irq_i       (irq_i),
      .per_req_i   (per_req_i),
      .x_mask_i    (x_mask_i),
      .i_mask_i    (i_mask_i),
      .req_o       (req),
      .intr_o      (intr)
   );

   exc_prio_sel u_sel (
      .req_i    (req),
      .base_i   (vbase_i),
      .per_ofs_i(per_ofs_i),
      .any_o    (any),
      .vec_o    (win_vec)
   );

   exc_vec_capture #(
      .RESET_VEC('0)
   ) u_cap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fetch_i  (fetch_i),
      .any_i    (any),
      .intr_i   (intr),
      .win_vec_i(win_vec),
      .base_i   (vbase_i),
      .vec_o    (vec_o),
      .valid_o  (vec_valid_o)
   );
endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        rst_pwr_i,
   input logic        rst_clkmon_i,
   input logic        rst_wdog_i,
   input logic        trap_op_i,
   input logic        trap_swi_i,
   input logic        trap_sys_i,
   input logic        cop_viol_i,
   input logic        cpu_viol_i,
   input logic        nmi_i,
   input logic        x_mask_i,
   input logic [7:0]  vbase_i,
   input logic        fetch_i,
   input logic [15:0] vec_o,
   input logic        vec_valid_o
);
   // R2
   pwr_reset_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_i && rst_pwr_i) |=> (vec_valid_o && vec_o == 16'hFFFE));

   // R5
   nmi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_i && nmi_i && !x_mask_i && !rst_pwr_i && !rst_clkmon_i && !rst_wdog_i
       && !trap_op_i && !trap_swi_i && !trap_sys_i && !cop_viol_i && !cpu_viol_i)
      |=> (vec_valid_o && vec_o == {$past(vbase_i), 8'hF4}));

   // R7
   even_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_o[0] == 1'b0);

   // R10
   hold_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fetch_i |=> (!vec_valid_o && $stable(vec_o)));

   // R10
   valid_needs_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_valid_o |-> $past(fetch_i));
endmodule

bind exc_vector_gen exc_vector_gen_chk u_chk (.*);

// File: tb/sim_exc_vector_gen.sv
module sim_exc_vector_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [10:0] req;  // {pwr,clk,wdog,op,swi,sys,cop,cpu,nmi,irq,per}
   logic        xm, im, fetch;
   logic [7:0]  ofs, base;
   logic [15:0] vec;
   logic        valid;

   exc_vector_gen u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .rst_pwr_i(req[10]), .rst_clkmon_i(req[9]), .rst_wdog_i(req[8]),
      .trap_op_i(req[7]), .trap_swi_i(req[6]), .trap_sys_i(req[5]),
      .cop_viol_i(req[4]), .cpu_viol_i(req[3]),
      .nmi_i(req[2]), .irq_i(req[1]), .per_req_i(req[0]),
      .per_ofs_i(ofs), .x_mask_i(xm), .i_mask_i(im), .vbase_i(base),
      .fetch_i(fetch), .vec_o(vec), .vec_valid_o(valid)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(string tag, logic [15:0] ev, logic evld);
      checks++;
      if (vec !== ev || valid !== evld) begin
         errors++;
         $display("FAIL %s: vec=%h valid=%b expected vec=%h valid=%b", tag, vec, valid, ev, evld);
      end
   endtask

   // drive at a falling edge, then wait one full cycle for the register
   task automatic step(logic [10:0] r, logic x, logic i, logic [7:0] o, logic [7:0] b, logic f);
      req = r; xm = x; im = i; ofs = o; base = b; fetch = f;
      @(negedge clk);
   endtask

   // {req, xm, im, ofs, base, exp_vec, exp_valid}
   localparam int N = 14;
   localparam logic [45:0] TBL [N] = '{
      {11'b11111111111, 2'b11, 8'h20, 8'h40, 16'hFFFE, 1'b1}, // R2
      {11'b01100100000, 2'b11, 8'h20, 8'h40, 16'hFFFC, 1'b1}, // R2
      {11'b00100000010, 2'b00, 8'h20, 8'h40, 16'hFFFA, 1'b1}, // R2
      {11'b00010010100, 2'b11, 8'h20, 8'h40, 16'h40F8, 1'b1}, // R3
      {11'b00001001000, 2'b11, 8'h20, 8'h41, 16'h41F6, 1'b1}, // R3
      {11'b00000110000, 2'b11, 8'h20, 8'h42, 16'h4212, 1'b1}, // R3
      {11'b00000011010, 2'b00, 8'h20, 8'h43, 16'h4316, 1'b1}, // R4
      {11'b00000001100, 2'b00, 8'h20, 8'h44, 16'h4414, 1'b1}, // R4
      {11'b00000000111, 2'b01, 8'h20, 8'h45, 16'h45F4, 1'b1}, // R5
      {11'b00000000110, 2'b10, 8'h20, 8'h46, 16'h46F2, 1'b1}, // R5 masked, R6
      {11'b00000000011, 2'b00, 8'h20, 8'h47, 16'h47F2, 1'b1}, // R6
      {11'b00000000001, 2'b00, 8'h3B, 8'h48, 16'h483A, 1'b1}, // R7
      {11'b00000000101, 2'b11, 8'h30, 8'h50, 16'h483A, 1'b0}, // R9 all masked
      {11'b00000000001, 2'b10, 8'hF0, 8'h49, 16'h49F0, 1'b1}  // R6
   };

   initial begin
      req = '0; xm = 1'b0; im = 1'b0; ofs = '0; base = '0; fetch = 1'b0;
      fork
         begin
            repeat (5000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: vec=%h valid=%b expected completion", vec, valid);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      join_none

      // R1: reset with a fetch and a request held
      @(negedge clk);
      step(11'b10000000000, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
      check("R1 during reset", 16'h0000, 1'b0);
      rst_n = 1'b1;
      step('0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
      check("R1 after reset", 16'h0000, 1'b0);

      for (int k = 0; k < N; k++) begin
         logic [45:0] e;
         logic [15:0] prev;
         e = TBL[k];
         prev = vec;
         step('0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
         check("R10 idle hold", prev, 1'b0);
         step(e[45:35], e[34], e[33], e[32:25], e[24:17], 1'b1);
         check($sformatf("R2-R9 table row %0d", k), e[16:1], e[0]);
      end

      // R10: requests present but no fetch
      step(11'b10000000000, 1'b0, 1'b0, 8'h00, 8'h60, 1'b0);
      check("R10 request without fetch", 16'h49F0, 1'b0);

      // R8: pin interrupt pending, gone at fetch
      step(11'b00000000010, 1'b0, 1'b0, 8'h00, 8'h61, 1'b0);
      step('0, 1'b0, 1'b0, 8'h00, 8'h61, 1'b1);
      check("R8 spurious from irq", 16'h6110, 1'b1);

      // R8: peripheral pending, gone at fetch
      step(11'b00000000001, 1'b0, 1'b0, 8'h44, 8'h62, 1'b0);
      step('0, 1'b0, 1'b0, 8'h00, 8'h62, 1'b1);
      check("R8 spurious from peripheral", 16'h6210, 1'b1);

      // R8: pending but masked earlier: no spurious
      step(11'b00000000011, 1'b0, 1'b1, 8'h44, 8'h63, 1'b0);
      step('0, 1'b0, 1'b0, 8'h00, 8'h63, 1'b1);
      check("R8 masked pending gives nothing", 16'h6210, 1'b0);

      // R9: fetch with nothing at all
      step('0, 1'b0, 1'b0, 8'h00, 8'h64, 1'b0);
      step('0, 1'b0, 1'b0, 8'h00, 8'h64, 1'b1);
      check("R9 empty fetch", 16'h6210, 1'b0);

      // R10: back-to-back fetches give one pulse each, then drop
      step(11'b00000000010, 1'b0, 1'b0, 8'h00, 8'h65, 1'b1);
      check("R6 back-to-back first", 16'h65F2, 1'b1);
      step(11'b00000001000, 1'b0, 1'b0, 8'h00, 8'h66, 1'b1);
      check("R4 back-to-back second", 16'h6614, 1'b1);
      step('0, 1'b0, 1'b0, 8'h00, 8'h66, 1'b0);
      check("R10 pulse ends", 16'h6614, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule